// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block holds the two error counters of a CAN node and turns them into the node's fault-confinement state. The protocol engine pulses one event input for each outcome it detects: a frame sent successfully, a frame received successfully, a transmit error or a receive error. The block updates an 8-bit transmit error count and an 8-bit receive error count from these pulses and derives one of three states. In error active the node uses active error flags. In error passive it uses passive error flags and waits out a suspend interval after each of its own transmissions. In bus off it is cut from the bus.

The outputs drive the transmitter directly. `flag_passive` selects the error-flag type. `suspend_req` holds off the start of the next transmission for a fixed number of bit times. `bus_isolate` disconnects the node. Leaving bus off requires a fixed number of observed idle sequences of 11 recessive bits. A CPU reads both counters as one 16-bit word at all times. It can overwrite them only while the controller is frozen.

Top module: `can_fault_conf`

## Requirements
- R1: `cpu_rdata` always reads {transmit count in bits 15:8, receive count in bits 7:0}. A write with `cpu_we` high loads bits 15:8 into the transmit count and bits 7:0 into the receive count on the next edge, but only while `freeze` is high. A write with `freeze` low changes nothing.
- R2: Outside bus off, `ev_tx_err` adds 8 to the transmit count. `ev_tx_ok` subtracts 1 and does not go below 0. When both are high in the same cycle, the error wins.
- R3: Outside bus off, `ev_rx_err` adds 1 to the receive count and holds at 255. `ev_rx_ok` subtracts 1 and does not go below 0. When both are high in the same cycle, the error wins.
- R4: `node_state` is 0 for error active, 1 for error passive and 2 for bus off. Outside bus off the node is passive exactly when either count is above 127.
- R5: An `ev_tx_err` that finds the transmit count at 248 or more enters bus off. The transmit count becomes 255 and `bus_isolate` goes high. While in bus off, all four event inputs are ignored.
- R6: While in bus off, each cycle with `recessive_11` high counts one idle sequence. The 128th sequence clears both counts and returns the node to error active. Pulses of `recessive_11` outside bus off have no effect.
- R7: `flag_passive` is high exactly when the node is error passive.
- R8: A `tx_done` pulse while the node is error passive raises `suspend_req` for 8 `bit_tick` pulses. A `tx_done` in any other state does not raise it. Bus off clears it.
- R9: When they fall in the same cycle, recovery clearing beats a CPU write, and a CPU write beats the event inputs.
- R10: Synchronous active-high `rst` clears both counts, leaves bus off and clears the suspend interval, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_ok | input | 1 | Frame transmitted successfully (pulse) |
| ev_rx_ok | input | 1 | Frame received successfully (pulse) |
| ev_tx_err | input | 1 | Transmit error detected (pulse) |
| ev_rx_err | input | 1 | Receive error detected (pulse) |
| recessive_11 | input | 1 | One sequence of 11 recessive bits seen (pulse) |
| tx_done | input | 1 | Own transmission finished (pulse) |
| bit_tick | input | 1 | One nominal bit time elapsed (pulse) |
| freeze | input | 1 | Controller is frozen; CPU writes allowed |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | CPU write data {tx count, rx count} |
| cpu_rdata | output | 16 | Counter read {tx count, rx count} |
| node_state | output | 2 | 0 active, 1 passive, 2 bus off |
| flag_passive | output | 1 | Send passive error flag |
| suspend_req | output | 1 | Delay start of next transmission |
| bus_isolate | output | 1 | Node disconnected from the bus |

## Verification
The bench targets the threshold edges: 127 against 128 on both counters, a transmit count of 247 (which lands on 255 and stays passive) against 248 (which enters bus off), and receive saturation at 255. A design off by one on any of these reports the wrong state or wraps a counter. It then counts recovery sequences up to the 127th and 128th, and lands a frozen CPU write on the same cycle as the final sequence. A wrong count or a wrong priority would leave the node isolated or restore the written values. A long pseudo-random run against an arithmetic model then catches suspend intervals that are one bit time off, and events that leak through while the node is bus off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic tx_ok;
        logic rx_ok;
        logic tx_err;
        logic rx_err;
    } fc_events_t;

    typedef struct packed {
        cnt_t tec;
        cnt_t rec;
    } fc_counts_t;

    function automatic cnt_t dec_floor(cnt_t v);
        return (v == '0) ? v : v - cnt_t'(1);
    endfunction

    function automatic cnt_t inc_sat(cnt_t v);
        return (v == '1) ? v : v + cnt_t'(1);
    endfunction

endpackage

// File: rtl/fc_counters.sv
module fc_counters
    import can_fc_pkg::*;
#(
    parameter int TX_ERR_INC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  fc_events_t ev,
    input  logic       bus_off,
    input  logic       clr,
    input  logic       wr_en,
    input  fc_counts_t wr_val,
    output fc_counts_t counts,
    output logic       tx_overflow
);

    logic [CNT_W:0] tec_sum;

    assign tec_sum     = {1'b0, counts.tec} + (CNT_W+1)'(TX_ERR_INC);
    assign tx_overflow = !bus_off && !clr && !wr_en && ev.tx_err && tec_sum[CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            counts <= '0;
        end else if (clr) begin
            counts <= '0;
        end else if (wr_en) begin
            counts <= wr_val;
        end else if (!bus_off) begin
            if (ev.tx_err)
                counts.tec <= tec_sum[CNT_W] ? '1 : tec_sum[CNT_W-1:0];
            else if (ev.tx_ok)
                counts.tec <= dec_floor(counts.tec);
            if (ev.rx_err)
                counts.rec <= inc_sat(counts.rec);
            else if (ev.rx_ok)
                counts.rec <= dec_floor(counts.rec);
        end
    end

    AST_TX_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en && !bus_off && ev.tx_err && !tec_sum[CNT_W])
        |=> counts.tec == $past(counts.tec) + cnt_t'(TX_ERR_INC)); // R2

    AST_RX_SAT: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en && counts.rec == '1 && ev.rx_err)
        |=> counts.rec == '1); // R3

    AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (bus_off && !clr && !wr_en) |=> $stable(counts)); // R5

endmodule

// File: rtl/fc_state.sv
module fc_state
    import can_fc_pkg::*;
#(
    parameter int PASSIVE_LIMIT = 127,
    parameter int RECOV_CNT     = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  fc_counts_t counts,
    input  logic       tx_overflow,
    input  logic       recessive_11,
    output fc_state_e  state,
    output logic       recov_done
);

    localparam int RC_W = $clog2(RECOV_CNT + 1);

    logic            bus_off_q;
    logic [RC_W-1:0] rc_q;

    assign recov_done = bus_off_q && recessive_11 && (rc_q == RC_W'(RECOV_CNT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_off_q <= 1'b0;
            rc_q      <= '0;
        end else if (tx_overflow) begin
            bus_off_q <= 1'b1;
            rc_q      <= '0;
        end else if (recov_done) begin
            bus_off_q <= 1'b0;
            rc_q      <= '0;
        end else if (bus_off_q && recessive_11) begin
            rc_q <= rc_q + RC_W'(1);
        end
    end

    always_comb begin
        if (bus_off_q)
            state = FC_BUSOFF;
        else if (counts.tec > cnt_t'(PASSIVE_LIMIT) || counts.rec > cnt_t'(PASSIVE_LIMIT))
            state = FC_PASSIVE;
        else
            state = FC_ACTIVE;
    end

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
        tx_overflow |=> state == FC_BUSOFF); // R5

    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!bus_off_q && !tx_overflow) |=> rc_q == '0); // R6

endmodule

// File: rtl/fc_suspend.sv
module fc_suspend
    import can_fc_pkg::*;
#(
    parameter int SUSP_BITS = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  fc_state_e state,
    input  logic      tx_done,
    input  logic      bit_tick,
    output logic      suspend_req
);

    localparam int SW = $clog2(SUSP_BITS + 1);

    logic [SW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || state == FC_BUSOFF)
            left_q <= '0;
        else if (tx_done && state == FC_PASSIVE)
            left_q <= SW'(SUSP_BITS);
        else if (bit_tick && left_q != '0)
            left_q <= left_q - SW'(1);
    end

    assign suspend_req = (left_q != '0);

    AST_SUSP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(suspend_req) |-> $past(tx_done && state == FC_PASSIVE)); // R8

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (suspend_req && !bit_tick && !tx_done && state != FC_BUSOFF) |=> suspend_req); // R8

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int TX_ERR_INC    = 8,
    parameter int PASSIVE_LIMIT = 127,
    parameter int RECOV_CNT     = 128,
    parameter int SUSP_BITS     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_tx_ok,
    input  logic        ev_rx_ok,
    input  logic        ev_tx_err,
    input  logic        ev_rx_err,
    input  logic        recessive_11,
    input  logic        tx_done,
    input  logic        bit_tick,
    input  logic        freeze,
    input  logic        cpu_we,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic [1:0]  node_state,
    output logic        flag_passive,
    output logic        suspend_req,
    output logic        bus_isolate
);

    fc_events_t ev;
    fc_counts_t counts;
    fc_counts_t wr_val;
    fc_state_e  state;
    logic       tx_overflow;
    logic       recov_done;
    logic       wr_en;

    assign ev     = '{tx_ok: ev_tx_ok, rx_ok: ev_rx_ok, tx_err: ev_tx_err, rx_err: ev_rx_err};
    assign wr_en  = cpu_we && freeze;
    assign wr_val = '{tec: cpu_wdata[15:8], rec: cpu_wdata[7:0]};

    fc_counters #(.TX_ERR_INC(TX_ERR_INC)) u_counters (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .bus_off     (state == FC_BUSOFF),
        .clr         (recov_done),
        .wr_en       (wr_en),
        .wr_val      (wr_val),
        .counts      (counts),
        .tx_overflow (tx_overflow)
    );

    fc_state #(.PASSIVE_LIMIT(PASSIVE_LIMIT), .RECOV_CNT(RECOV_CNT)) u_state (
        .clk          (clk),
        .rst          (rst),
        .counts       (counts),
        .tx_overflow  (tx_overflow),
        .recessive_11 (recessive_11),
        .state        (state),
        .recov_done   (recov_done)
    );

    fc_suspend #(.SUSP_BITS(SUSP_BITS)) u_suspend (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .tx_done     (tx_done),
        .bit_tick    (bit_tick),
        .suspend_req (suspend_req)
    );

    assign cpu_rdata    = {counts.tec, counts.rec};
    assign node_state   = state;
    assign flag_passive = (state == FC_PASSIVE);
    assign bus_isolate  = (state == FC_BUSOFF);

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !freeze && !bus_isolate && !ev_tx_ok && !ev_rx_ok && !ev_tx_err && !ev_rx_err)
        |=> $stable(cpu_rdata)); // R1

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && freeze && !recov_done) |=> cpu_rdata == $past(cpu_wdata)); // R1

    AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_isolate) |-> (cpu_rdata == 16'h0000 && node_state == 2'd0)); // R6

    AST_ISOLATED_NO_SUSPEND: assert property (@(posedge clk) disable iff (rst)
        $past(bus_isolate) |-> !suspend_req); // R8

endmodule

// File: tb/test_can_fault_conf.sv
module test_can_fault_conf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_tx_err = 0, ev_rx_err = 0;
    logic        recessive_11 = 0, tx_done = 0, bit_tick = 0;
    logic        freeze = 0, cpu_we = 0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [1:0]  node_state;
    logic        flag_passive, suspend_req, bus_isolate;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // model state
    int  m_tec = 0, m_rec = 0, m_rc = 0, m_sc = 0;
    bit  m_busoff = 0;

    always #10 clk = ~clk;   // 50 MHz

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst(rst),
        .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err),
        .recessive_11(recessive_11), .tx_done(tx_done), .bit_tick(bit_tick),
        .freeze(freeze), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .node_state(node_state), .flag_passive(flag_passive),
        .suspend_req(suspend_req), .bus_isolate(bus_isolate)
    );

    function automatic int m_state();
        if (m_busoff) return 2;
        if (m_tec > 127 || m_rec > 127) return 1;
        return 0;
    endfunction

    task automatic check(string req, string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s): actual %0d expected %0d", req, tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check("R1/R2 tx count", tag, int'(cpu_rdata[15:8]), m_tec);
        check("R1/R3 rx count", tag, int'(cpu_rdata[7:0]),  m_rec);
        check("R4 state",       tag, int'(node_state),      m_state());
        check("R7 flag",        tag, int'(flag_passive),    int'(m_state() == 1));
        check("R5 isolate",     tag, int'(bus_isolate),     int'(m_busoff));
        check("R8 suspend",     tag, int'(suspend_req),     int'(m_sc != 0));
    endtask

    // apply one clock edge to the model using the current inputs
    task automatic model_edge();
        bit wr   = cpu_we && freeze;
        bit rdn  = m_busoff && recessive_11 && (m_rc == 127);
        bit ovf  = !m_busoff && !wr && ev_tx_err && (m_tec >= 248);
        int st   = m_state();
        // R8 suspend interval
        if (st == 2)                  m_sc = 0;
        else if (tx_done && st == 1)  m_sc = 8;
        else if (bit_tick && m_sc > 0) m_sc--;
        // R9 precedence: recovery, then write, then events
        if (rdn) begin
            m_tec = 0; m_rec = 0;
        end else if (wr) begin
            m_tec = int'(cpu_wdata[15:8]); m_rec = int'(cpu_wdata[7:0]);
        end else if (!m_busoff) begin
            if (ev_tx_err)     m_tec = (m_tec + 8 > 255) ? 255 : m_tec + 8;
            else if (ev_tx_ok) m_tec = (m_tec > 0) ? m_tec - 1 : 0;
            if (ev_rx_err)     m_rec = (m_rec < 255) ? m_rec + 1 : 255;
            else if (ev_rx_ok) m_rec = (m_rec > 0) ? m_rec - 1 : 0;
        end
        // R5 / R6 bus-off tracking
        if (ovf)                            begin m_busoff = 1; m_rc = 0; end
        else if (rdn)                       begin m_busoff = 0; m_rc = 0; end
        else if (m_busoff && recessive_11)  m_rc++;
    endtask

    task automatic clear_inputs();
        ev_tx_ok = 0; ev_rx_ok = 0; ev_tx_err = 0; ev_rx_err = 0;
        recessive_11 = 0; tx_done = 0; bit_tick = 0; cpu_we = 0; freeze = 0;
        cpu_wdata = '0;
    endtask

    // inputs already driven; clock once, update model, check at negedge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        clear_inputs();
    endtask

    task automatic cpu_write(logic [15:0] v, string tag);
        freeze = 1; cpu_we = 1; cpu_wdata = v;
        step(tag);
    endtask

    // watchdog
    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 200000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R10 reset state");

        // R1: write ignored without freeze
        cpu_we = 1; freeze = 0; cpu_wdata = 16'h5A5A;
        step("R1 write locked");
        cpu_write(16'h7780, "R1 frozen write, R4 rx 128 passive");

        // R2 / R4 tx threshold 127 vs 128
        cpu_write(16'h7800, "R1 set tx 120");
        ev_tx_err = 1; step("R2 tx 120+8 -> 128 passive R4");
        ev_tx_ok = 1;  step("R2 tx 128-1 -> 127 active R4");

        // R3 rx threshold and saturation
        cpu_write(16'h007F, "R1 set rx 127");
        ev_rx_err = 1; step("R3 rx 127+1 passive");
        ev_rx_ok = 1; ev_rx_err = 1; step("R3 error beats ok");
        cpu_write(16'h00FF, "R1 set rx 255");
        ev_rx_err = 1; step("R3 rx saturates");
        cpu_write(16'h0000, "R1 clear");
        ev_rx_ok = 1; ev_tx_ok = 1; step("R2 R3 floor at zero");
        ev_tx_err = 1; ev_tx_ok = 1; step("R2 error beats ok");

        // R5 bus off boundary
        cpu_write(16'hF700, "R1 set tx 247");
        ev_tx_err = 1; step("R5 tx 247 -> 255 no bus off");
        ev_tx_ok = 1;  step("R2 tx 254");
        cpu_write(16'hF800, "R1 set tx 248");
        ev_tx_err = 1; step("R5 tx 248 enters bus off");
        ev_rx_err = 1; ev_tx_ok = 1; step("R5 events ignored in bus off");
        tx_done = 1;   step("R8 no suspend in bus off");

        // R6 recovery: 127 pulses, with gaps
        for (int k = 0; k < 127; k++) begin
            recessive_11 = 1; step("R6 counting sequences");
            if (k % 16 == 0) step("R6 gap");
        end
        check("R6 still bus off after 127", "directed", int'(bus_isolate), 1);
        recessive_11 = 1; freeze = 1; cpu_we = 1; cpu_wdata = 16'h9999;
        step("R6 R9 128th clears over write");
        check("R9 recovery beats write", "directed", int'(cpu_rdata), 0);
        recessive_11 = 1; step("R6 pulse outside bus off ignored");

        // R8 suspend interval
        tx_done = 1; step("R8 no suspend when active");
        cpu_write(16'h8000, "R1 set tx 128");
        tx_done = 1; step("R8 suspend starts");
        for (int k = 0; k < 8; k++) begin
            bit_tick = 1; step("R8 suspend countdown");
            step("R8 suspend holds without tick");
        end
        check("R8 suspend over after 8 ticks", "directed", int'(suspend_req), 0);

        // pseudo-random sweep against the model
        for (int n = 0; n < 40000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ev_tx_err    = (lfsr[2:0] == 3'd0) || (lfsr[2:0] == 3'd1);
            ev_tx_ok     = (lfsr[5:3] == 3'd2);
            ev_rx_err    = (lfsr[8:6] < 3'd3);
            ev_rx_ok     = (lfsr[11:9] < 3'd2);
            recessive_11 = lfsr[12] | lfsr[13];
            tx_done      = (lfsr[16:14] == 3'd5);
            bit_tick     = lfsr[17];
            freeze       = (lfsr[23:18] == 6'd7);
            cpu_we       = lfsr[24];
            cpu_wdata    = {lfsr[31:25], lfsr[26], lfsr[30:23]};
            step("R2 R3 R4 R5 R6 R8 R9 sweep");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule